// File: doc/BRIEF.md
# Bit-Matrix Least-Recently-Used Tracker

This block keeps the recency state of N entries, for example the ways of one cache set or the page frames of a small translation buffer, and names the entry that has gone longest without use. State lives in an N-by-N square of flip-flops. When entry k is touched, the whole of row k is set and then the whole of column k is cleared. Each row, read as a binary number, then sits below the rows of entries touched after it and above the rows of entries touched before it.

One access is taken per clock on a valid strobe with an index. The victim index and the full ranking from oldest to newest come out combinationally from the registered square, so they reflect every access up to the previous clock. A synchronous clear returns the square to all zeros. The replacement storage and the miss path that uses the victim are outside this block.

Top module: `lru_matrix_tracker`

## Requirements
- R1: After the asynchronous reset (rst_n low) or a synchronous clear (clr_i high at a rising edge), every bit of the square is zero. The ranking is then the identity (slot s holds index s) and lru_idx_o is 0. lru_vld_o is 0 while rst_n is low and for the one cycle after a clear is taken, and 1 otherwise.
- R2: An access (acc_vld_i high with index k) updates the square at the next rising edge: row k becomes all ones, then column k becomes all zeros. In the following cycle k is the most recently used entry, in slot N-1 of order_o.
- R3: lru_idx_o is the row with the smallest value, with column 0 read as the most significant bit. When rows tie, the lowest index is chosen, so the initial victim is 0.
- R4: order_o lists the indices by increasing row value, oldest first. Slot s sits at bits [s*IW +: IW], where IW = clog2(N). Slot 0 always equals lru_idx_o.
- R5: In a cycle with neither an access nor a clear, the square, order_o and lru_idx_o keep their values.
- R6: When clr_i and acc_vld_i are both high in the same cycle, the clear wins and the access leaves no trace.
- R7: With N = 4, the access string 0,1,2,3,2,1,0,3,2,3 after reset gives a ranking that matches pure recency after every step. It ends with order 1,0,2,3, oldest first, and victim 1.
- R8: For N > 1, the cycle after an access never names the accessed index as the victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous clear of all recency state |
| acc_vld_i | input | 1 | An access is presented this cycle |
| acc_idx_i | input | IW | Index of the accessed entry |
| lru_idx_o | output | IW | Least recently used index |
| lru_vld_o | output | 1 | Recency outputs are settled (low in reset and after a clear) |
| order_o | output | N*IW | Full ranking, slot 0 oldest, slot N-1 newest |

## Verification
The bench builds the tracker with N = 4, which keeps the square at sixteen bits. At that size every four-access string after a clear, all 256 of them, can be applied. A reference list that moves each touched index to the tail predicts the expected ranking arithmetically. A long pseudo-random stream then mixes idle cycles, clears and clear-with-access collisions. The stated ten-access string is checked step by step, together with its final victim.

// File: rtl/lru_mx_pkg.sv
package lru_mx_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/lru_mx_store.sv
module lru_mx_store #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            acc_vld_i,
  input  logic [IW-1:0]   acc_idx_i,
  output logic [N*N-1:0]  rows_o,
  output logic            vld_o
);
  // row i occupies rows_o[i*N +: N]; column c sits at bit N-1-c of its row
  logic [N*N-1:0] rows_q, rows_d;
  logic           rows_en;
  logic           vld_q, vld_d;

  always_comb begin
    rows_en = clr_i | acc_vld_i;
    vld_d   = ~clr_i;
    rows_d  = rows_q;
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] row_t;
      row_t = rows_q[i*N +: N];
      if (clr_i) begin
        row_t = '0;
      end else if (acc_vld_i) begin
        if (int'(acc_idx_i) == i) row_t = '1;
        for (int c = 0; c < N; c++) begin
          if (int'(acc_idx_i) == c) row_t[N-1-c] = 1'b0;
        end
      end
      rows_d[i*N +: N] = row_t;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rows_q <= '0;
    end else if (rows_en) begin
      rows_q <= rows_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  assign rows_o = rows_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/lru_mx_rank.sv
module lru_mx_rank #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N*N-1:0]  rows_i,
  output logic [N*IW-1:0] rank_o,
  output logic [IW-1:0]   min_idx_o
);
  // rank of row i: rows strictly smaller, plus equal rows of lower index
  for (genvar gi = 0; gi < N; gi++) begin : g_rank
    always_comb begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < N; j++) begin
        if (rows_i[j*N +: N] < rows_i[gi*N +: N]) cnt++;
        else if ((rows_i[j*N +: N] == rows_i[gi*N +: N]) && (j < gi)) cnt++;
      end
      rank_o[gi*IW +: IW] = IW'(cnt);
    end
  end

  // independent minimum search; strict compare keeps the lowest index on ties
  always_comb begin
    logic [N-1:0] best_v;
    min_idx_o = '0;
    best_v    = rows_i[N-1:0];
    for (int i = 1; i < N; i++) begin
      if (rows_i[i*N +: N] < best_v) begin
        best_v    = rows_i[i*N +: N];
        min_idx_o = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lru_mx_order.sv
module lru_mx_order #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic [N*IW-1:0] rank_i,
  output logic [N*IW-1:0] order_o
);
  for (genvar gs = 0; gs < N; gs++) begin : g_slot
    always_comb begin
      order_o[gs*IW +: IW] = '0;
      for (int i = 0; i < N; i++) begin
        if (int'(rank_i[i*IW +: IW]) == gs) order_o[gs*IW +: IW] = IW'(i);
      end
    end
  end
endmodule

// File: rtl/lru_matrix_tracker.sv
module lru_matrix_tracker
  import lru_mx_pkg::*;
#(
  parameter int N  = 8,
  parameter int IW = idx_width(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            acc_vld_i,
  input  logic [IW-1:0]   acc_idx_i,
  output logic [IW-1:0]   lru_idx_o,
  output logic            lru_vld_o,
  output logic [N*IW-1:0] order_o
);
  localparam int NBITS = N * N;

  logic [NBITS-1:0] rows;
  logic [N*IW-1:0]  rank;

  lru_mx_store #(.N(N), .IW(IW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .acc_vld_i (acc_vld_i),
    .acc_idx_i (acc_idx_i),
    .rows_o    (rows),
    .vld_o     (lru_vld_o)
  );

  lru_mx_rank #(.N(N), .IW(IW)) u_rank (
    .rows_i    (rows),
    .rank_o    (rank),
    .min_idx_o (lru_idx_o)
  );

  lru_mx_order #(.N(N), .IW(IW)) u_order (
    .rank_i  (rank),
    .order_o (order_o)
  );
endmodule

// File: rtl/lru_matrix_tracker_chk.sv
module lru_matrix_tracker_chk #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            clr_i,
  input logic            acc_vld_i,
  input logic [IW-1:0]   acc_idx_i,
  input logic [IW-1:0]   lru_idx_o,
  input logic            lru_vld_o,
  input logic [N*IW-1:0] order_o
);
  function automatic logic [N*IW-1:0] ident();
    logic [N*IW-1:0] v;
    for (int s = 0; s < N; s++) v[s*IW +: IW] = IW'(s);
    return v;
  endfunction

  a_r1_clear_ident: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (lru_idx_o == '0) && (order_o == ident()));

  a_r1_clear_vld: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !lru_vld_o);

  a_r2_mru_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_vld_i && !clr_i) |=> order_o[(N-1)*IW +: IW] == $past(acc_idx_i));

  a_r4_slot0_is_lru: assert property (@(posedge clk) disable iff (!rst_n)
    order_o[IW-1:0] == lru_idx_o);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_vld_i && !clr_i) |=> $stable(order_o) && $stable(lru_idx_o));

  a_r6_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && acc_vld_i) |=> (order_o == ident()));

  if (N > 1) begin : g_r8
    a_r8_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_vld_i && !clr_i) |=> lru_idx_o != $past(acc_idx_i));
  end
endmodule

bind lru_matrix_tracker lru_matrix_tracker_chk #(.N(N), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr_i     (clr_i),
  .acc_vld_i (acc_vld_i),
  .acc_idx_i (acc_idx_i),
  .lru_idx_o (lru_idx_o),
  .lru_vld_o (lru_vld_o),
  .order_o   (order_o)
);

// File: tb/lru_matrix_tracker_bench.sv
module lru_matrix_tracker_bench;
  localparam int PERIOD = 10;
  localparam int N      = 4;
  localparam int IW     = 2;

  logic            clk;
  logic            rst_n;
  logic            clr_i;
  logic            acc_vld_i;
  logic [IW-1:0]   acc_idx_i;
  logic [IW-1:0]   lru_idx_o;
  logic            lru_vld_o;
  logic [N*IW-1:0] order_o;

  int total = 0;
  int bad   = 0;
  int lst[N];   // reference recency list, lst[0] oldest
  bit finished = 0;

  lru_matrix_tracker #(.N(N), .IW(IW)) u_lru_matrix_tracker (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .acc_vld_i(acc_vld_i),
    .acc_idx_i(acc_idx_i), .lru_idx_o(lru_idx_o), .lru_vld_o(lru_vld_o),
    .order_o(order_o)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  function automatic void model_clear();
    for (int s = 0; s < N; s++) lst[s] = s;
  endfunction

  function automatic void model_touch(input int k);
    int p;
    p = 0;
    for (int s = 0; s < N; s++) if (lst[s] == k) p = s;
    for (int s = p; s < N-1; s++) lst[s] = lst[s+1];
    lst[N-1] = k;
  endfunction

  function automatic logic [N*IW-1:0] model_order();
    logic [N*IW-1:0] v;
    for (int s = 0; s < N; s++) v[s*IW +: IW] = IW'(lst[s]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input bit exp_vld);
    chk(order_o == model_order(), {req, "/R4 order"}, int'(order_o), int'(model_order()));
    chk(lru_idx_o == IW'(lst[0]), {req, "/R3 victim"}, int'(lru_idx_o), lst[0]);
    chk(lru_vld_o == exp_vld, {req, "/R1 valid"}, int'(lru_vld_o), int'(exp_vld));
  endtask

  task automatic step(input bit v, input int k, input bit c, input string req);
    @(negedge clk);
    acc_vld_i = v;
    acc_idx_i = IW'(k);
    clr_i     = c;
    @(posedge clk);
    #1;
    if (c) model_clear();
    else if (v) model_touch(k);
    check_all(req, !c);
    if (v && !c)
      chk(lru_idx_o != IW'(k), "R8 accessed index not victim", int'(lru_idx_o), k);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seq[10];
    logic [15:0] lfsr;
    seq = '{0, 1, 2, 3, 2, 1, 0, 3, 2, 3};
    rst_n = 1'b0; clr_i = 1'b0; acc_vld_i = 1'b0; acc_idx_i = '0;
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset", 1'b0);

    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check_all("R1 after release", 1'b1);

    // R7 stated string, ranking compared after every access
    for (int i = 0; i < 10; i++) step(1'b1, seq[i], 1'b0, "R7 R2 string");
    chk(lru_idx_o == 2'd1, "R7 final victim", int'(lru_idx_o), 1);
    chk(order_o == {2'd3, 2'd2, 2'd0, 2'd1}, "R7 final order", int'(order_o), 8'hE1);

    // R5 idle cycles hold
    for (int i = 0; i < 3; i++) step(1'b0, 0, 1'b0, "R5 idle hold");

    // R6 clear collides with access
    step(1'b1, 2, 1'b1, "R6 clear with access");
    step(1'b0, 0, 1'b0, "R6 after clear");

    // R1 asynchronous reset mid-run
    step(1'b1, 1, 1'b0, "R2 before reset");
    step(1'b1, 3, 1'b0, "R2 before reset");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    model_clear();
    check_all("R1 async reset", 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 0, 1'b0, "R1 after second release");

    // exhaustive: every 4-access string after a clear
    for (int a = 0; a < 256; a++) begin
      step(1'b0, 0, 1'b1, "R1 clear");
      for (int d = 0; d < 4; d++) step(1'b1, (a >> (2*d)) & 3, 1'b0, "R2 sweep");
    end

    // pseudo-random mix of accesses, idles and clears
    lfsr = 16'hACE1;
    for (int i = 0; i < 2000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[7:3] == 5'd0)      step(lfsr[8], int'(lfsr[1:0]), 1'b1, "R6 random clear");
      else if (lfsr[6:4] == 3'd1) step(1'b0, int'(lfsr[1:0]), 1'b0, "R5 random idle");
      else                        step(1'b1, int'(lfsr[1:0]), 1'b0, "R2 random access");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule